// File: doc/BRIEF.md
# Three-register host mailbox responder

This block is the controller side of a byte-wide host mailbox with three registers. The host selects a register with a two-bit offset. Offset 0 carries a data byte in either direction. At offset 1 the host writes a control code and reads back a status code. Offset 2 holds the handshake flags.

To issue a command, the host writes the data byte and the control code, then sets the busy flag. The responder accepts the command and puts the matching status and data in place. It clears busy in the same cycle, so status and data are valid whenever busy reads 0.

Request bytes are collected into a buffer of `DEPTH` entries. Real request handling is not part of the block. In its place, once a write phase ends without error, the responder waits `LOOP_DELAY` cycles and then offers the same bytes back as the response. The host reads them one per command, and the status code marks the final byte. A test input drives the flag that announces an unsolicited message.

Top module: `mbox_responder`

## Requirements
- R1: After reset, status reads 0xC0, data reads 0x00 and flags read 0x40.
- R2: Host register offsets are:
  - offset 0: data; writes latch the next request byte.
  - offset 1: writes go to control and reads return status. A control write alone never shows up in status.
  - offset 2: flags.
  - offset 3: reads 0x00.
- R3: An accepted control code is answered with the same code plus bit 7 (0x41→0xC1, and so on). Code 0x40 is legal in every phase: it gives status 0xC0 and data 0x00 and abandons any transaction in progress.
- R4: A host write to offset 2 with bit 0 set raises busy (flag bit 0). Busy reads 1 in the cycle after that write and 0 one cycle later, when status and data have been updated.
- R5: A write phase is:
  - 0x41 from ready, which stores the first byte;
  - any number of 0x42, each storing one byte;
  - 0x43, which stores the last byte.
  At 0x43, the data register reads 0x00 if no more than `DEPTH` bytes were sent. Data reads 0x00 after 0x41 and 0x42 as well.
- R6: If more than `DEPTH` bytes are sent, 0x43 reports status 0xC3 with data 0x05. No response is offered afterwards.
- R7: A control code not legal in the current phase gives status 0xC0 and data 0x02, and returns the responder to ready. This covers any code outside 0x40–0x46, and 0x42–0x46 sent from ready.
- R8: The flag bits are as follows:
  - Bit 7 (response byte waiting) is 0 during the wait after a successful 0x43.
  - Bit 7 rises exactly `LOOP_DELAY` cycles after busy clears.
  - Bit 6 (request byte accepted) is 1 only in ready or write phase while not busy.
- R9: The response holds the request bytes in order:
  - 0x44 gives status 0xC4 with the first byte.
  - Each 0x45 gives the next byte, with 0xC5 while bytes remain and 0xC6 on the last.
  - Bit 7 of the flags is 0 after the last byte.
- R10: 0x46 after the last byte gives status 0xC0 and data 0x00. 0x46 sent earlier in the read phase gives status 0xC0 and data 0x01.
- R11: The message-available flag (bit 2) follows the test input. Flag bits 1, 3, 4 and 5 read 0, so the flags never read 0xFF. A host write to offset 2 changes no flag other than busy.
- R12: A data byte written in the cycle when a command is being accepted does not affect that command. It is kept for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected offset (combinational) |
| msg_avail_in | input | 1 | Test input for the message-available flag |

## Verification
The responder accepts a command in the cycle after busy is raised. A host may already be writing its next data byte to offset 0 in that same cycle. The bench provokes this by driving the busy handoff and a new data byte on consecutive cycles just before a write-end. It then reads the loopback response and checks that the final byte is the one written before the handoff, not the late byte. The scoreboard compares every status and data pair a command produces against values derived from the requirements.

// File: rtl/mbox_responder.sv
`timescale 1ns/1ps
module mbox_responder #(
  parameter int DEPTH      = 80,
  parameter int LOOP_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       msg_avail_in
);
  localparam int IW = $clog2(DEPTH + 1);
  localparam int DW = $clog2(LOOP_DELAY + 1);
  localparam logic [IW-1:0] FULL    = IW'(DEPTH);
  localparam logic [DW-1:0] DLY_END = DW'(LOOP_DELAY - 1);
  localparam logic [7:0] ST_READY  = 8'hC0;
  localparam logic [7:0] C_GET     = 8'h40;
  localparam logic [7:0] C_WSTART  = 8'h41;
  localparam logic [7:0] C_WNEXT   = 8'h42;
  localparam logic [7:0] C_WEND    = 8'h43;
  localparam logic [7:0] C_RSTART  = 8'h44;
  localparam logic [7:0] C_RNEXT   = 8'h45;
  localparam logic [7:0] C_REND    = 8'h46;
  localparam logic [7:0] ERR_ABORT = 8'h01;
  localparam logic [7:0] ERR_CTRL  = 8'h02;
  localparam logic [7:0] ERR_FULL  = 8'h05;

  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_WAIT, PH_RD} phase_t;

  phase_t        phase_q;
  logic          busy_q, ovf_q;
  logic [7:0]    ctrl_q, in_q, status_q, data_q;
  logic [IW-1:0] wcnt_q, rptr_q;
  logic [DW-1:0] dly_q;
  logic [7:0]    mem_q [DEPTH];

  wire wr_data  = host_wr && host_addr == 2'd0;
  wire wr_ctrl  = host_wr && host_addr == 2'd1;
  wire wr_flags = host_wr && host_addr == 2'd2;

  wire has_room = wcnt_q < FULL;
  wire rx_rdy   = (phase_q == PH_RD) && (rptr_q < wcnt_q);
  wire tx_rdy   = !busy_q && (phase_q == PH_IDLE || (phase_q == PH_WR && has_room));
  wire [7:0] flags = {rx_rdy, tx_rdy, 3'b000, msg_avail_in, 1'b0, busy_q};

  wire do_start = busy_q && ctrl_q == C_WSTART && phase_q == PH_IDLE;
  wire do_wmore = busy_q && (ctrl_q == C_WNEXT || ctrl_q == C_WEND) && phase_q == PH_WR;
  wire mem_we   = do_start || (do_wmore && has_room);
  wire [IW-1:0] mem_idx = do_start ? '0 : wcnt_q;
  wire [IW-1:0] rd_last = wcnt_q - IW'(1);

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = data_q;
      2'd1:    host_rdata = status_q;
      2'd2:    host_rdata = flags;
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[mem_idx] <= in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      busy_q   <= 1'b0;
      ovf_q    <= 1'b0;
      ctrl_q   <= 8'h00;
      in_q     <= 8'h00;
      status_q <= ST_READY;
      data_q   <= 8'h00;
      wcnt_q   <= '0;
      rptr_q   <= '0;
      dly_q    <= '0;
    end else begin
      if (wr_data) in_q   <= host_wdata;
      if (wr_ctrl) ctrl_q <= host_wdata;
      if (busy_q) begin
        busy_q   <= 1'b0;
        status_q <= ST_READY;
        data_q   <= 8'h00;
        phase_q  <= PH_IDLE;
        if (ctrl_q == C_GET) begin
        end else if (do_start) begin
          wcnt_q   <= IW'(1);
          ovf_q    <= 1'b0;
          status_q <= 8'hC1;
          phase_q  <= PH_WR;
        end else if (do_wmore) begin
          status_q <= ctrl_q | 8'h80;
          if (has_room) wcnt_q <= wcnt_q + IW'(1);
          else          ovf_q  <= 1'b1;
          if (ctrl_q == C_WNEXT) phase_q <= PH_WR;
          else if (ovf_q || !has_room) data_q <= ERR_FULL;
          else begin
            phase_q <= PH_WAIT;
            dly_q   <= '0;
          end
        end else if (ctrl_q == C_RSTART && phase_q == PH_RD && rptr_q == '0) begin
          status_q <= 8'hC4;
          data_q   <= mem_q[0];
          rptr_q   <= IW'(1);
          phase_q  <= PH_RD;
        end else if (ctrl_q == C_RNEXT && rx_rdy && rptr_q != '0) begin
          status_q <= (rptr_q == rd_last) ? 8'hC6 : 8'hC5;
          data_q   <= mem_q[rptr_q];
          rptr_q   <= rptr_q + IW'(1);
          phase_q  <= PH_RD;
        end else if (ctrl_q == C_REND && phase_q == PH_RD && rptr_q != '0) begin
          data_q <= rx_rdy ? ERR_ABORT : 8'h00;
        end else begin
          data_q <= ERR_CTRL;
        end
      end else begin
        if (wr_flags && host_wdata[0]) busy_q <= 1'b1;
        if (phase_q == PH_WAIT) begin
          if (dly_q == DLY_END) begin
            phase_q <= PH_RD;
            rptr_q  <= '0;
          end else begin
            dly_q <= dly_q + DW'(1);
          end
        end
      end
    end
  end

  assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);

  assert_flags_not_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flags != 8'hFF);

  assert_full_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wmore && ctrl_q == C_WEND && !has_room) |=> (data_q == ERR_FULL && phase_q == PH_IDLE));

  assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (ctrl_q[7:3] != 5'b01000 || ctrl_q[2:0] == 3'b111)) |=>
      (data_q == ERR_CTRL && status_q == ST_READY));

  assert_rx_after_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(phase_q) == PH_WAIT);

  assert_final_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'hC6 && !busy_q) |-> !rx_rdy);
endmodule

// File: tb/test_mbox_responder.sv
`timescale 1ns/1ps
module test_mbox_responder;
  localparam int DEPTH = 80;
  localparam int LOOP_DELAY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       msg_avail_in = 1'b0;

  always #5 clk = ~clk;

  mbox_responder #(.DEPTH(DEPTH), .LOOP_DELAY(LOOP_DELAY)) i_mbox_responder (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .msg_avail_in(msg_avail_in));

  typedef struct {
    logic [7:0] st;
    logic [7:0] dt;
    string      req;
  } item_t;

  item_t exp_q[$];
  item_t obs_q[$];
  int checks = 0;
  int fails = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 3 + 7);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    peek(a, v);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] f;
    int n = 0;
    do begin rd(2'd2, f); n++; end while (f[0] && n < 20);
    chk(f & 8'h01, 8'h00, req, "busy cleared");
  endtask

  task automatic wait_rx(input string req);
    logic [7:0] f;
    int n = 0;
    do begin rd(2'd2, f); n++; end while (!f[7] && n < 40);
    chk({7'd0, f[7]}, 8'h01, req, "response byte waiting");
  endtask

  task automatic cmd(input logic [7:0] c, input logic [7:0] b,
                     input logic [7:0] es, input logic [7:0] ed, input string req);
    logic [7:0] f, s, d;
    item_t e, o;
    wr(2'd0, b);
    wr(2'd1, c);
    wr(2'd2, 8'h01);
    peek(2'd2, f); chk(f & 8'h01, 8'h01, "R4", "busy after handoff");
    rd(2'd2, f);   chk(f & 8'h01, 8'h00, "R4", "busy one cycle later");
    rd(2'd1, s);
    rd(2'd0, d);
    e.st = es; e.dt = ed; e.req = req;
    o.st = s;  o.dt = d;  o.req = req;
    exp_q.push_back(e);
    obs_q.push_back(o);
  endtask

  initial begin : monitor
    item_t o, e;
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        chk(o.st, e.st, e.req, "status");
        chk(o.dt, e.dt, e.req, "data");
      end
    end
  end

  initial begin : watchdog
    #2000000;
    checks++; fails++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd1, v); chk(v, 8'hC0, "R1", "status after reset");
    rd(2'd0, v); chk(v, 8'h00, "R1", "data after reset");
    rd(2'd2, v); chk(v, 8'h40, "R1", "flags after reset");
    rd(2'd3, v); chk(v, 8'h00, "R2", "offset 3 reads zero");

    msg_avail_in = 1'b1;
    rd(2'd2, v); chk(v, 8'h44, "R11", "message flag follows input");
    wr(2'd2, 8'hFE);
    rd(2'd2, v); chk(v, 8'h44, "R11", "host flag write without busy ignored");
    msg_avail_in = 1'b0;
    wr(2'd1, 8'h41);
    rd(2'd1, v); chk(v, 8'hC0, "R2", "control write not visible in status");

    cmd(8'h41, 8'hA1, 8'hC1, 8'h00, "R3");
    cmd(8'h42, 8'hB2, 8'hC2, 8'h00, "R3");
    cmd(8'h43, 8'hC3, 8'hC3, 8'h00, "R5");
    rd(2'd2, v); chk(v, 8'h00, "R8", "no response during delay");
    rd(2'd2, v); chk(v, 8'h80, "R8", "response waiting after delay");
    cmd(8'h44, 8'h00, 8'hC4, 8'hA1, "R9");
    cmd(8'h45, 8'h00, 8'hC5, 8'hB2, "R9");
    cmd(8'h45, 8'h00, 8'hC6, 8'hC3, "R9");
    rd(2'd2, v); chk(v, 8'h00, "R9", "no byte waiting after final");
    cmd(8'h46, 8'h00, 8'hC0, 8'h00, "R10");
    rd(2'd2, v); chk(v, 8'h40, "R8", "ready accepts bytes again");

    cmd(8'h45, 8'h00, 8'hC0, 8'h02, "R7");
    cmd(8'h47, 8'h00, 8'hC0, 8'h02, "R7");
    cmd(8'h12, 8'h00, 8'hC0, 8'h02, "R7");
    cmd(8'h44, 8'h00, 8'hC0, 8'h02, "R7");

    cmd(8'h41, 8'h11, 8'hC1, 8'h00, "R5");
    cmd(8'h43, 8'h22, 8'hC3, 8'h00, "R5");
    wait_rx("R8");
    cmd(8'h44, 8'h00, 8'hC4, 8'h11, "R9");
    cmd(8'h46, 8'h00, 8'hC0, 8'h01, "R10");

    cmd(8'h41, 8'h33, 8'hC1, 8'h00, "R3");
    cmd(8'h40, 8'h00, 8'hC0, 8'h00, "R3");
    cmd(8'h42, 8'h44, 8'hC0, 8'h02, "R7");

    cmd(8'h41, pat(0), 8'hC1, 8'h00, "R5");
    for (int i = 1; i < DEPTH - 1; i++) cmd(8'h42, pat(i), 8'hC2, 8'h00, "R5");
    cmd(8'h43, pat(DEPTH - 1), 8'hC3, 8'h00, "R5");
    wait_rx("R8");
    cmd(8'h44, 8'h00, 8'hC4, pat(0), "R9");
    for (int i = 1; i < DEPTH - 1; i++) cmd(8'h45, 8'h00, 8'hC5, pat(i), "R9");
    cmd(8'h45, 8'h00, 8'hC6, pat(DEPTH - 1), "R9");
    cmd(8'h46, 8'h00, 8'hC0, 8'h00, "R10");

    cmd(8'h41, pat(0), 8'hC1, 8'h00, "R6");
    for (int i = 1; i < DEPTH; i++) cmd(8'h42, pat(i), 8'hC2, 8'h00, "R6");
    cmd(8'h43, 8'hEE, 8'hC3, 8'h05, "R6");
    repeat (LOOP_DELAY + 3) @(negedge clk);
    rd(2'd2, v); chk(v, 8'h40, "R6", "no response after overflow");

    cmd(8'h41, 8'h5A, 8'hC1, 8'h00, "R12");
    wr(2'd0, 8'h66);
    wr(2'd1, 8'h43);
    @(negedge clk);
    host_addr = 2'd2; host_wdata = 8'h01; host_wr = 1'b1;
    @(negedge clk);
    host_addr = 2'd0; host_wdata = 8'h99;
    @(negedge clk);
    host_wr = 1'b0;
    wait_idle("R12");
    rd(2'd1, v); chk(v, 8'hC3, "R12", "write-end status with late data byte");
    rd(2'd0, v); chk(v, 8'h00, "R12", "write-end completion with late data byte");
    wait_rx("R12");
    cmd(8'h44, 8'h00, 8'hC4, 8'h5A, "R12");
    cmd(8'h45, 8'h00, 8'hC6, 8'h66, "R12");
    cmd(8'h46, 8'h00, 8'hC0, 8'h00, "R10");

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule